// File: doc/BRIEF.md
# Bus-Matching Width Adapter

This block sits between a FIFO's storage array and its external ports and moves data between a 36-bit internal word and port words of 36, 18 or 9 bits. On the write side it packs successive narrow input words into one long word for storage. On the read side it splits each long word taken from storage into successive narrow output words. Every side uses a valid/ready handshake. Storage, flag generation and clock crossing belong to neighbouring blocks.

The input width, the output width and the byte order are sampled from configuration pins while reset is held low, and they stay fixed until the next reset. The byte order applies in both directions. Big-endian puts the first narrow word at the top of the long word, and the most significant part is the first one sent out. Little-endian does the reverse. When the input and output widths match, each port word maps to exactly one storage word, and the byte order has no effect.

The block reports two counts, both in units of the selected port word. One is the number of narrow words held in a partly packed long word. The other is the number of narrow words still waiting to be sent from the long word being split.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low the block latches `cfg_in_sel`, `cfg_out_sel` and `cfg_little`. The select codes are 2'b00 = 36 bits, 2'b01 = 18 bits, 2'b10 = 9 bits, and 2'b11 is treated as 36 bits. Pin changes after reset has been released have no effect until the next reset.
- R2: `cfg_little` low at reset selects big-endian order. `cfg_little` high at reset selects little-endian order.
- R3: Packing in big-endian order places the first narrow word in the top part of the long word (bits 35:27 for 9-bit input, bits 35:18 for 18-bit input). Later words go into successively lower parts.
- R4: Packing in little-endian order places the first narrow word in the bottom part (bits 8:0 or 17:0). Later words go into successively higher parts.
- R5: Splitting in big-endian order sends the most significant part of the long word first. Each narrow word appears on the low bits of `rd_data`, and all bits above the output width are zero.
- R6: Splitting in little-endian order sends the least significant part first, then the more significant parts in rising order.
- R7: A packed long word appears on `st_valid` only after all of its narrow parts have been accepted. `pack_fill` equals the number of narrow words accepted so far for the word being built.
- R8: `split_left` equals the number of narrow words of the current long word not yet delivered. `ld_ready` is high only when no part remains, or when the last part is being delivered in that same cycle. A refused output keeps `rd_data` stable.
- R9: When the input and output widths are equal, each accepted input word becomes one storage word holding the port-width low bits, with the upper bits zero. Each storage word becomes one output word made of its port-width low bits.
- R10: While `st_valid` is high and `st_ready` is low, `st_data` holds steady and `wr_ready` is low.
- R11: Reset throws away any partly packed or partly split word. After reset `pack_fill` and `split_left` are zero, `st_valid` and `rd_valid` are low, and `wr_ready` and `ld_ready` are high.
- R12: Bits of `wr_data` above the selected input width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_in_sel | input | 2 | Input port width select |
| cfg_out_sel | input | 2 | Output port width select |
| cfg_little | input | 1 | Byte order select: low = big-endian, high = little-endian |
| wr_valid | input | 1 | Narrow input word valid |
| wr_ready | output | 1 | Adapter can take an input word |
| wr_data | input | 36 | Input word, right-aligned |
| st_valid | output | 1 | Packed long word valid towards storage |
| st_ready | input | 1 | Storage accepts the long word |
| st_data | output | 36 | Packed long word |
| ld_valid | input | 1 | Long word from storage valid |
| ld_ready | output | 1 | Adapter can take a long word |
| ld_data | input | 36 | Long word from storage |
| rd_valid | output | 1 | Narrow output word valid |
| rd_ready | input | 1 | Reader accepts the narrow word |
| rd_data | output | 36 | Output word, right-aligned, upper bits zero |
| pack_fill | output | 3 | Narrow words held in the partly packed word |
| split_left | output | 3 | Narrow words still to be sent from the current long word |

## Verification
The packing path is driven with 9-bit and 18-bit words in both byte orders. The word values differ from each other, and garbage sits above the port width, so any swapped, shifted or leaked lane shows up in the stored word. The splitting path gets a long word whose every nibble is distinct. It is run with 9-bit and 18-bit outputs in both orders, with and without read back-pressure. This separates ordering faults from count faults and from refill-timing faults. Equal-width runs at 18 and at 36 bits check that pass-through adds no reordering and no extra parts. A reset in the middle of a word, and configuration pins changed after reset, show that partial state is dropped and that only the reset-time settings count.

// File: rtl/bwc_pkg.sv
// Shared types and helpers for the bus-matching width adapter.
// Assumes the internal word is made of a lane count divisible by four.
package bwc_pkg;

    typedef enum logic [1:0] {
        SEL_FULL    = 2'b00,
        SEL_HALF    = 2'b01,
        SEL_QUARTER = 2'b10,
        SEL_SPARE   = 2'b11
    } wsel_e;

    typedef struct packed {
        wsel_e in_sel;
        wsel_e out_sel;
        logic  little;
    } bwc_cfg_t;

    // Lanes occupied by one port word of the given select.
    function automatic int unsigned lanes_of(wsel_e s, int unsigned total);
        case (s)
            SEL_HALF:    return total / 2;
            SEL_QUARTER: return total / 4;
            default:     return total;
        endcase
    endfunction

    // Port words making up one internal word for the given select.
    function automatic int unsigned parts_of(wsel_e s);
        case (s)
            SEL_HALF:    return 2;
            SEL_QUARTER: return 4;
            default:     return 1;
        endcase
    endfunction

endpackage

// File: rtl/bwc_cfg_latch.sv
// Configuration capture for the width adapter.
// Samples the select pins on every clock while reset is low and holds them
// afterwards. Derives the per-side lane width and part count; equal widths
// collapse both sides to a single part (pass-through).
module bwc_cfg_latch
    import bwc_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned LCW = $clog2(LANES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     in_sel_i,
    input  logic [1:0]     out_sel_i,
    input  logic           little_i,
    output bwc_cfg_t       cfg_o,
    output logic [LCW-1:0] pack_lanes_o,
    output logic [LCW-1:0] pack_parts_o,
    output logic [LCW-1:0] split_lanes_o,
    output logic [LCW-1:0] split_parts_o
);

    bwc_cfg_t cfg_q;
    logic     same_w;

    // Capture the pins only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{in_sel: wsel_e'(in_sel_i), out_sel: wsel_e'(out_sel_i), little: little_i};
        end
    end

    // Derive lane widths and part counts for both directions.
    always_comb begin
        same_w        = (lanes_of(cfg_q.in_sel, LANES) == lanes_of(cfg_q.out_sel, LANES));
        pack_lanes_o  = LCW'(lanes_of(cfg_q.in_sel, LANES));
        split_lanes_o = LCW'(lanes_of(cfg_q.out_sel, LANES));
        pack_parts_o  = same_w ? LCW'(1) : LCW'(parts_of(cfg_q.in_sel));
        split_parts_o = same_w ? LCW'(1) : LCW'(parts_of(cfg_q.out_sel));
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/bwc_pack.sv
// Narrow-to-wide packer. Collects nparts right-aligned narrow words into one
// long word, placing each by byte order, and offers it downstream.
// Assumes part_lanes * nparts equals LANES, or nparts is one.
// A new word may start in the cycle the finished one leaves.
module bwc_pack #(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DW  = LANE_W * LANES,
    localparam int unsigned LCW = $clog2(LANES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LCW-1:0] part_lanes,
    input  logic [LCW-1:0] nparts,
    input  logic           little,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DW-1:0]  in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic [LCW-1:0] fill
);

    logic [LCW-1:0] cnt;
    logic [LCW-1:0] slot;
    logic           full;
    logic [DW-1:0]  acc;
    logic [DW-1:0]  low_mask;
    logic [DW-1:0]  merged;
    int unsigned    off;

    // Mask covering one port word at the bottom of the long word.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign low_mask[g*LANE_W +: LANE_W] = (LCW'(g) < part_lanes) ? '1 : '0;
    end

    assign in_ready = !full || out_ready;

    // Place the incoming narrow word at its slot over the running word.
    always_comb begin
        slot   = little ? cnt : (nparts - LCW'(1) - cnt);
        off    = int'(slot) * int'(part_lanes) * LANE_W;
        merged = ((full ? '0 : acc) & ~(low_mask << off)) | ((in_data & low_mask) << off);
    end

    // Advance the part counter and release the word on its last part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            full <= 1'b0;
            acc  <= '0;
        end else begin
            if (full && out_ready) begin
                full <= 1'b0;
            end
            if (in_valid && in_ready) begin
                acc <= merged;
                if (cnt == nparts - LCW'(1)) begin
                    cnt  <= '0;
                    full <= 1'b1;
                end else begin
                    cnt <= cnt + LCW'(1);
                end
            end
        end
    end

    assign out_valid = full;
    assign out_data  = acc;
    assign fill      = cnt;

endmodule

// File: rtl/bwc_split.sv
// Wide-to-narrow splitter. Holds one long word and sends nparts narrow
// words from it in byte order, right-aligned with zeroed upper bits.
// Takes the next long word in the cycle its last part leaves.
module bwc_split #(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DW  = LANE_W * LANES,
    localparam int unsigned LCW = $clog2(LANES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LCW-1:0] part_lanes,
    input  logic [LCW-1:0] nparts,
    input  logic           little,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DW-1:0]  in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic [LCW-1:0] left
);

    logic [DW-1:0]  hold;
    logic [DW-1:0]  low_mask;
    logic [LCW-1:0] idx;
    logic [LCW-1:0] slot;
    logic           busy;
    logic           last;
    int unsigned    off;

    // Mask covering one port word at the bottom of the long word.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign low_mask[g*LANE_W +: LANE_W] = (LCW'(g) < part_lanes) ? '1 : '0;
    end

    assign last     = (idx == nparts - LCW'(1));
    assign in_ready = !busy || (last && out_ready);

    // Select the part due now and right-align it.
    always_comb begin
        slot     = little ? idx : (nparts - LCW'(1) - idx);
        off      = int'(slot) * int'(part_lanes) * LANE_W;
        out_data = (hold >> off) & low_mask;
    end

    // Step through parts and reload when the word is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            idx  <= '0;
            busy <= 1'b0;
        end else begin
            if (busy && out_ready) begin
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + LCW'(1);
                end
            end
            if (in_valid && in_ready) begin
                hold <= in_data;
                idx  <= '0;
                busy <= 1'b1;
            end
        end
    end

    assign out_valid = busy;
    assign left      = busy ? (nparts - idx) : '0;

endmodule

// File: rtl/bus_width_adapter.sv
// Bus-matching width adapter top. Packs narrow write-port words into long
// storage words and splits long storage words into narrow read-port words.
// Widths and byte order come from pins sampled during reset.
// Assumes LANES is a multiple of four; narrow data is right-aligned.
module bus_width_adapter
    import bwc_pkg::*;
#(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DW  = LANE_W * LANES,
    localparam int unsigned LCW = $clog2(LANES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     cfg_in_sel,
    input  logic [1:0]     cfg_out_sel,
    input  logic           cfg_little,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [DW-1:0]  wr_data,
    output logic           st_valid,
    input  logic           st_ready,
    output logic [DW-1:0]  st_data,
    input  logic           ld_valid,
    output logic           ld_ready,
    input  logic [DW-1:0]  ld_data,
    output logic           rd_valid,
    input  logic           rd_ready,
    output logic [DW-1:0]  rd_data,
    output logic [LCW-1:0] pack_fill,
    output logic [LCW-1:0] split_left
);

    bwc_cfg_t       cfg_q;
    logic [LCW-1:0] pack_lanes;
    logic [LCW-1:0] pack_parts;
    logic [LCW-1:0] split_lanes;
    logic [LCW-1:0] split_parts;

    bwc_cfg_latch #(.LANES(LANES)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_sel_i     (cfg_in_sel),
        .out_sel_i    (cfg_out_sel),
        .little_i     (cfg_little),
        .cfg_o        (cfg_q),
        .pack_lanes_o (pack_lanes),
        .pack_parts_o (pack_parts),
        .split_lanes_o(split_lanes),
        .split_parts_o(split_parts)
    );

    bwc_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .part_lanes(pack_lanes),
        .nparts    (pack_parts),
        .little    (cfg_q.little),
        .in_valid  (wr_valid),
        .in_ready  (wr_ready),
        .in_data   (wr_data),
        .out_valid (st_valid),
        .out_ready (st_ready),
        .out_data  (st_data),
        .fill      (pack_fill)
    );

    bwc_split #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .part_lanes(split_lanes),
        .nparts    (split_parts),
        .little    (cfg_q.little),
        .in_valid  (ld_valid),
        .in_ready  (ld_ready),
        .in_data   (ld_data),
        .out_valid (rd_valid),
        .out_ready (rd_ready),
        .out_data  (rd_data),
        .left      (split_left)
    );

endmodule

// File: rtl/bus_width_adapter_checker.sv
// Protocol and state checks for the width adapter, bound to the top.
module bus_width_adapter_checker
    import bwc_pkg::*;
#(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DW  = LANE_W * LANES,
    localparam int unsigned LCW = $clog2(LANES + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input bwc_cfg_t       cfg_word,
    input logic [LCW-1:0] pack_parts,
    input logic           wr_valid,
    input logic           wr_ready,
    input logic           st_valid,
    input logic           st_ready,
    input logic [DW-1:0]  st_data,
    input logic           ld_ready,
    input logic           rd_valid,
    input logic           rd_ready,
    input logic [DW-1:0]  rd_data,
    input logic [LCW-1:0] pack_fill,
    input logic [LCW-1:0] split_left
);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_word)); // R1

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pack_fill < pack_parts); // R7

    AST_ST_AFTER_PART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> $past(wr_valid && wr_ready)); // R7

    AST_LD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> (split_left == '0) || (split_left == LCW'(1) && rd_ready)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8

    AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_data)); // R10

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |-> !wr_ready); // R10

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> pack_fill == '0 && split_left == '0 && !st_valid && !rd_valid); // R11

endmodule

bind bus_width_adapter bus_width_adapter_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_q),
    .pack_parts(pack_parts),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .ld_ready  (ld_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .pack_fill (pack_fill),
    .split_left(split_left)
);

// File: tb/bus_width_adapter_bench.sv
// Directed bench for the width adapter: one task per scenario.
module bus_width_adapter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel_in = 2'b00;
    logic [1:0]  sel_out = 2'b00;
    logic        order_le = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [35:0] wr_data = '0;
    logic        st_valid;
    logic        st_ready = 1'b1;
    logic [35:0] st_data;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [35:0] ld_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [35:0] rd_data;
    logic [2:0]  pack_fill;
    logic [2:0]  split_left;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [35:0] st_log[$];
    logic [35:0] rd_log[$];

    always #5 clk = ~clk;

    bus_width_adapter u_bus_width_adapter (
        .clk(clk), .rst_n(rst_n),
        .cfg_in_sel(sel_in), .cfg_out_sel(sel_out), .cfg_little(order_le),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .pack_fill(pack_fill), .split_left(split_left)
    );

    // Record every completed transfer on the storage and read sides.
    always @(posedge clk) begin
        if (rst_n && st_valid && st_ready) st_log.push_back(st_data);
        if (rst_n && rd_valid && rd_ready) rd_log.push_back(rd_data);
    end

    task automatic chk_eq(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reset with the given pins, then scramble the pins (R1).
    task automatic do_reset(input logic [1:0] isel, input logic [1:0] osel, input logic le);
        @(negedge clk);
        rst_n = 1'b0; sel_in = isel; sel_out = osel; order_le = le;
        wr_valid = 1'b0; ld_valid = 1'b0; st_ready = 1'b1; rd_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; sel_in = ~isel; sel_out = ~osel; order_le = ~le;
        st_log.delete(); rd_log.delete();
    endtask

    task automatic push(input logic [35:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0; wr_data = '1;
    endtask

    task automatic feed(input logic [35:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = d;
        while (!ld_ready) @(negedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(2'b00, 2'b00, 1'b0);
        chk_eq("R11 wr_ready", {35'd0, wr_ready}, 36'd1);
        chk_eq("R11 ld_ready", {35'd0, ld_ready}, 36'd1);
        chk_eq("R11 valids", {34'd0, st_valid, rd_valid}, 36'd0);
        chk_eq("R11 counts", {30'd0, pack_fill, split_left}, 36'd0);
    endtask

    // 9-bit input, big then little, upper bits set to junk (R3 R4 R7 R12 R1 R2).
    task automatic t_pack_quarter();
        do_reset(2'b10, 2'b00, 1'b0);
        push({27'h7FF_FFFF, 9'h1A5});
        push({27'h5A5_A5A5, 9'h0C3});
        chk_eq("R7 fill after two", {33'd0, pack_fill}, 36'd2);
        chk_eq("R7 nothing stored early", 36'(st_log.size()), 36'd0);
        push({27'h000_0F0F, 9'h07E});
        push({27'h3C3_C3C3, 9'h111});
        repeat (2) @(negedge clk);
        chk_eq("R7 one word stored", 36'(st_log.size()), 36'd1);
        chk_eq("R3 R12 R1 big pack 9", st_log[0], {9'h1A5, 9'h0C3, 9'h07E, 9'h111});
        do_reset(2'b10, 2'b00, 1'b1);
        push(36'h0000_001A5); push(36'hFFFF_FE0C3); push(36'h0000_0007E); push(36'h1234_56111);
        repeat (2) @(negedge clk);
        chk_eq("R4 R2 little pack 9", st_log[0], {9'h111, 9'h07E, 9'h0C3, 9'h1A5});
    endtask

    task automatic t_pack_half();
        do_reset(2'b01, 2'b00, 1'b0);
        push({18'h3FFFF, 18'h2B3C4}); push({18'h15555, 18'h0D1E2});
        repeat (2) @(negedge clk);
        chk_eq("R3 big pack 18", st_log[0], {18'h2B3C4, 18'h0D1E2});
        do_reset(2'b01, 2'b00, 1'b1);
        push({18'h3FFFF, 18'h2B3C4}); push({18'h15555, 18'h0D1E2});
        repeat (2) @(negedge clk);
        chk_eq("R4 little pack 18", st_log[0], {18'h0D1E2, 18'h2B3C4});
    endtask

    task automatic t_split();
        logic [35:0] x;
        x = 36'h9_8765_4321;
        do_reset(2'b00, 2'b10, 1'b0);
        feed(x);
        repeat (6) @(negedge clk);
        chk_eq("R5 count 9", 36'(rd_log.size()), 36'd4);
        chk_eq("R5 big part0", rd_log[0], {27'd0, x[35:27]});
        chk_eq("R5 big part1", rd_log[1], {27'd0, x[26:18]});
        chk_eq("R5 big part3", rd_log[3], {27'd0, x[8:0]});
        do_reset(2'b00, 2'b01, 1'b1);
        feed(x);
        repeat (4) @(negedge clk);
        chk_eq("R6 count 18", 36'(rd_log.size()), 36'd2);
        chk_eq("R6 little part0", rd_log[0], {18'd0, x[17:0]});
        chk_eq("R6 little part1", rd_log[1], {18'd0, x[35:18]});
    endtask

    // Split under read back-pressure, refusal of a new long word (R8 R6).
    task automatic t_split_hold();
        logic [35:0] x;
        logic [35:0] y;
        x = 36'hA_BCDE_F012;
        y = 36'h1_2345_6789;
        do_reset(2'b00, 2'b10, 1'b1);
        rd_ready = 1'b0;
        feed(x);
        chk_eq("R8 left full", {33'd0, split_left}, 36'd4);
        chk_eq("R6 first little part", rd_data, {27'd0, x[8:0]});
        ld_valid = 1'b1; ld_data = y;
        chk_eq("R8 ld refused while busy", {35'd0, ld_ready}, 36'd0);
        repeat (3) @(negedge clk);
        ld_valid = 1'b0;
        chk_eq("R8 rd_data held", rd_data, {27'd0, x[8:0]});
        rd_ready = 1'b1;
        @(negedge clk);
        chk_eq("R8 left after one", {33'd0, split_left}, 36'd3);
        feed(y);
        repeat (8) @(negedge clk);
        chk_eq("R8 total parts", 36'(rd_log.size()), 36'd8);
        chk_eq("R8 x last part", rd_log[3], {27'd0, x[35:27]});
        chk_eq("R8 y first part", rd_log[4], {27'd0, y[8:0]});
    endtask

    task automatic t_pass();
        do_reset(2'b01, 2'b01, 1'b0);
        push({18'h3FFFF, 18'h0ABCD});
        push({18'h12345, 18'h30F0F});
        repeat (2) @(negedge clk);
        chk_eq("R9 one store per word", 36'(st_log.size()), 36'd2);
        chk_eq("R9 pass 18 store0", st_log[0], 36'h0_0000_ABCD);
        chk_eq("R9 pass 18 store1", st_log[1], {18'd0, 18'h30F0F});
        feed(36'hF_FFF1_2345);
        repeat (3) @(negedge clk);
        chk_eq("R9 one read per word", 36'(rd_log.size()), 36'd1);
        chk_eq("R9 pass 18 read", rd_log[0], {18'd0, 18'h12345});
        do_reset(2'b00, 2'b00, 1'b1);
        push(36'hC_0FFE_E123);
        feed(36'h5_A5A5_0F0F);
        repeat (3) @(negedge clk);
        chk_eq("R9 pass 36 store", st_log[0], 36'hC_0FFE_E123);
        chk_eq("R9 pass 36 read", rd_log[0], 36'h5_A5A5_0F0F);
    endtask

    task automatic t_backpressure();
        logic [35:0] held;
        do_reset(2'b10, 2'b00, 1'b0);
        st_ready = 1'b0;
        push(36'h0_0000_0001); push(36'h0_0000_0002); push(36'h0_0000_0003); push(36'h0_0000_0004);
        chk_eq("R10 st_valid", {35'd0, st_valid}, 36'd1);
        chk_eq("R10 wr_ready low", {35'd0, wr_ready}, 36'd0);
        held = st_data;
        repeat (3) @(negedge clk);
        chk_eq("R10 st_data held", st_data, held);
        st_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk_eq("R10 word after release", st_log[0], {9'd1, 9'd2, 9'd3, 9'd4});
    endtask

    task automatic t_reset_mid();
        do_reset(2'b10, 2'b00, 1'b0);
        push(36'h0_0000_01FF); push(36'h0_0000_01EE);
        do_reset(2'b10, 2'b00, 1'b0);
        chk_eq("R11 fill cleared", {33'd0, pack_fill}, 36'd0);
        push(36'h0_0000_0011); push(36'h0_0000_0022); push(36'h0_0000_0033); push(36'h0_0000_0044);
        repeat (2) @(negedge clk);
        chk_eq("R11 single fresh word", 36'(st_log.size()), 36'd1);
        chk_eq("R11 partial dropped", st_log[0], {9'h11, 9'h22, 9'h33, 9'h44});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_pack_quarter();
        t_pack_half();
        t_split();
        t_split_hold();
        t_pass();
        t_backpressure();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule